// File: doc/BRIEF.md
# I2C Clock Divider Search Engine

This block finds the timing settings an I2C master needs to run its serial clock at a requested rate. It takes the functional clock frequency in hertz, the requested SCL rate in hertz and two small trim constants, one for the low phase and one for the high phase. It then looks for an 8-bit prescaler together with an 8-bit low-period count and an 8-bit high-period count. If no prescaler value gives usable counts, it raises a failure flag instead.

The search is sequential. Prescaler candidates are tried from 0 upward. For each candidate the block performs two integer divisions on one shared restoring shift-subtract divider, which produces one quotient bit per cycle. The first divides the functional clock by the candidate plus one to get a sample clock. The second divides that sample clock by twice the requested rate, so each count covers half an SCL period. Each phase trim is subtracted from this count, and the candidate is accepted when both trimmed counts fall inside their allowed windows.

Software or a boot sequencer pulses `start` with the operands on the inputs. It waits for the one-cycle `done` pulse and then reads the registered result, which holds until the next accepted request completes.

Top module: `i2c_clkdiv_search`

## Requirements
- R1: For an accepted prescaler p, with D = floor(floor(F / (p+1)) / (2·S)), the outputs are `low_cnt` = D − trim_lo and `high_cnt` = D − trim_hi. Here F is `fclk_hz`, S is `scl_hz`, and the trims are taken from `trim_lo` and `trim_hi`.
- R2: A candidate p is accepted when all four of these hold: D − trim_lo > 0, D − trim_hi > 0, D − trim_lo ≤ 255 − trim_lo, and D − trim_hi ≤ 255 − trim_hi.
- R3: Candidates are tried in increasing order from 0. The reported `psc` is the smallest accepted value, and `fail` is 0 when a result is reported.
- R4: If no candidate from 0 to 255 inclusive is accepted, the block reports `fail` = 1 with `psc`, `low_cnt` and `high_cnt` all 0.
- R5: A request with `scl_hz` = 0 fails at once. `done` and `fail` are both 1 right after the rising edge that samples `start`.
- R6: `done` is high for exactly one cycle. Count rising edges after the edge that samples `start`: `done` rises on edge 69·(p+1) for an accepted p, and on edge 69·256 = 17664 for a search failure.
- R7: `busy` is 1 from the edge that samples `start` until the edge that raises `done`, and `done` is 0 while `busy` is 1. A `start` pulse while `busy` is 1 is ignored and does not change the result of the running search.
- R8: `psc`, `low_cnt`, `high_cnt` and `fail` change only on the edge that raises `done`. At all other times they hold their last values.
- R9: After a synchronous active-low reset, `busy`, `done`, `fail`, `psc`, `low_cnt` and `high_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; operands are sampled on the same edge |
| fclk_hz | input | 32 | Functional clock frequency in Hz |
| scl_hz | input | 32 | Requested SCL rate in Hz |
| trim_lo | input | 8 | Trim subtracted from the low-phase count |
| trim_hi | input | 8 | Trim subtracted from the high-phase count |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | No usable prescaler was found |
| psc | output | 8 | Selected prescaler |
| low_cnt | output | 8 | SCL low-phase count |
| high_cnt | output | 8 | SCL high-phase count |

## Verification
The `done` edge count is exactly 69 cycles per candidate tried. Because of this, a divider that runs one step too many or too few, or a state machine that skips or repeats a candidate, shows up at the ports as a wrong completion cycle on the very first request. That happens even when the reported values are still correct. A wrong quotient bit or a wrong window comparison appears instead as a wrong `psc` or wrong count at `done`. Near the window edges it can also move the search onto a different prescaler, which shifts the completion cycle by multiples of 69. A corrupted hold register shows up as an output that changes between completions; this is checked on every idle cycle.

// File: rtl/i2c_srch_pkg.sv
// Shared types for the I2C clock divider search.
// Assumes nothing beyond the standard types.
package i2c_srch_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DIV_SMP = 2'd1,
        ST_DIV_CNT = 2'd2,
        ST_CHECK   = 2'd3
    } srch_state_t;
endpackage

// File: rtl/i2c_srch_div.sv
// Restoring shift-subtract unsigned divider that produces one quotient bit per cycle.
// Assumes the operands are held stable for the whole run and that the divisor is nonzero.
// A load happens on go. Done pulses one cycle after the last of NUM_W steps.
module i2c_srch_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] numer,
    input  logic [DEN_W-1:0] denom,
    output logic             fin,
    output logic [NUM_W-1:0] quot
);
    localparam int REM_W = DEN_W + 1;
    localparam int STP_W = $clog2(NUM_W + 1);

    logic [REM_W-1:0] rem_q;
    logic [NUM_W-1:0] shf_q;
    logic [STP_W-1:0] steps_q;
    logic             run_q;
    logic [REM_W-1:0] rem_shift;
    logic [REM_W-1:0] rem_sub;
    logic             fits;

    // Next partial remainder, and whether the divisor fits into it.
    always_comb begin
        rem_shift = {rem_q[REM_W-2:0], shf_q[NUM_W-1]};
        rem_sub   = rem_shift - REM_W'(denom);
        fits      = rem_shift >= REM_W'(denom);
    end

    // Iteration registers: load on go, then perform one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            shf_q   <= '0;
            steps_q <= '0;
            run_q   <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q   <= '0;
                shf_q   <= numer;
                steps_q <= STP_W'(NUM_W);
                run_q   <= 1'b1;
            end else if (run_q) begin
                rem_q   <= fits ? rem_sub : rem_shift;
                shf_q   <= {shf_q[NUM_W-2:0], fits};
                steps_q <= steps_q - 1'b1;
                if (steps_q == STP_W'(1)) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quot = shf_q;
endmodule

// File: rtl/i2c_srch_win.sv
// Window test for one SCL phase: subtracts the trim from the base count and checks
// that the result is positive and no greater than the count ceiling minus the trim.
// The check is purely combinational and assumes BASE_W is at least CNT_W.
module i2c_srch_win #(
    parameter int BASE_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic [BASE_W-1:0] base,
    input  logic [CNT_W-1:0]  trim,
    output logic              ok,
    output logic [CNT_W-1:0]  cnt
);
    localparam int SW = BASE_W + 2;

    logic signed [SW-1:0] diff;
    logic signed [SW-1:0] ceil_v;

    // Signed trimmed count and its ceiling, then the window decision.
    always_comb begin
        diff   = $signed({2'b00, base}) - $signed(SW'(trim));
        ceil_v = $signed(SW'((1 << CNT_W) - 1)) - $signed(SW'(trim));
        ok     = (diff > 0) && (diff <= ceil_v);
        cnt    = diff[CNT_W-1:0];
    end
endmodule

// File: rtl/i2c_clkdiv_search.sv
// Top of the I2C clock divider search. It latches the operands on start and walks the
// prescaler candidates upward. For each candidate it runs two divisions on the shared
// divider and tests both phase windows. It reports the first candidate that passes, or
// failure. It assumes the operands only matter on the edge that samples start.
module i2c_clkdiv_search
    import i2c_srch_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int PSC_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] fclk_hz,
    input  logic [FREQ_W-1:0] scl_hz,
    input  logic [CNT_W-1:0]  trim_lo,
    input  logic [CNT_W-1:0]  trim_hi,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [PSC_W-1:0]  psc,
    output logic [CNT_W-1:0]  low_cnt,
    output logic [CNT_W-1:0]  high_cnt
);
    localparam int         DEN_W    = FREQ_W + 1;
    localparam int         NPHASE   = 2;
    localparam [PSC_W-1:0] PSC_LAST = '1;

    srch_state_t       state_q;
    logic [FREQ_W-1:0] fclk_q, speed_q, smp_q, base_q;
    logic [CNT_W-1:0]  trim_q [NPHASE];
    logic [PSC_W-1:0]  try_q;
    logic              go_q;
    logic [FREQ_W-1:0] numer;
    logic [DEN_W-1:0]  denom;
    logic              div_fin;
    logic [FREQ_W-1:0] div_quot;
    logic              win_ok  [NPHASE];
    logic [CNT_W-1:0]  win_cnt [NPHASE];
    logic              all_ok;

    // Operand select: the sample-clock division first, then the count division.
    always_comb begin
        if (state_q == ST_DIV_CNT) begin
            numer = smp_q;
            denom = {speed_q, 1'b0};
        end else begin
            numer = fclk_q;
            denom = DEN_W'(try_q) + DEN_W'(1);
        end
    end

    i2c_srch_div #(.NUM_W(FREQ_W), .DEN_W(DEN_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go_q),
        .numer (numer),
        .denom (denom),
        .fin   (div_fin),
        .quot  (div_quot)
    );

    // One window test per phase: index 0 is the low phase, index 1 the high phase.
    for (genvar g = 0; g < NPHASE; g++) begin : g_phase
        i2c_srch_win #(.BASE_W(FREQ_W), .CNT_W(CNT_W)) u_win (
            .base (base_q),
            .trim (trim_q[g]),
            .ok   (win_ok[g]),
            .cnt  (win_cnt[g])
        );
    end

    assign all_ok = win_ok[0] && win_ok[1];

    // Search sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            fclk_q    <= '0;
            speed_q   <= '0;
            smp_q     <= '0;
            base_q    <= '0;
            trim_q[0] <= '0;
            trim_q[1] <= '0;
            try_q     <= '0;
            go_q      <= 1'b0;
            done      <= 1'b0;
            fail      <= 1'b0;
            psc       <= '0;
            low_cnt   <= '0;
            high_cnt  <= '0;
        end else begin
            go_q <= 1'b0;
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (scl_hz == '0) begin
                            done     <= 1'b1;
                            fail     <= 1'b1;
                            psc      <= '0;
                            low_cnt  <= '0;
                            high_cnt <= '0;
                        end else begin
                            fclk_q    <= fclk_hz;
                            speed_q   <= scl_hz;
                            trim_q[0] <= trim_lo;
                            trim_q[1] <= trim_hi;
                            try_q     <= '0;
                            go_q      <= 1'b1;
                            state_q   <= ST_DIV_SMP;
                        end
                    end
                end
                ST_DIV_SMP: begin
                    if (div_fin) begin
                        smp_q   <= div_quot;
                        go_q    <= 1'b1;
                        state_q <= ST_DIV_CNT;
                    end
                end
                ST_DIV_CNT: begin
                    if (div_fin) begin
                        base_q  <= div_quot;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (all_ok) begin
                        done     <= 1'b1;
                        fail     <= 1'b0;
                        psc      <= try_q;
                        low_cnt  <= win_cnt[0];
                        high_cnt <= win_cnt[1];
                        state_q  <= ST_IDLE;
                    end else if (try_q == PSC_LAST) begin
                        done     <= 1'b1;
                        fail     <= 1'b1;
                        psc      <= '0;
                        low_cnt  <= '0;
                        high_cnt <= '0;
                        state_q  <= ST_IDLE;
                    end else begin
                        try_q   <= try_q + 1'b1;
                        go_q    <= 1'b1;
                        state_q <= ST_DIV_SMP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/i2c_clkdiv_search_chk.sv
// Property checker for the I2C clock divider search, bound to every instance of the top.
// It observes the ports only.
module i2c_clkdiv_search_chk #(
    parameter int FREQ_W = 32,
    parameter int PSC_W  = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [FREQ_W-1:0] scl_hz,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [PSC_W-1:0]  psc,
    input logic [CNT_W-1:0]  low_cnt,
    input logic [CNT_W-1:0]  high_cnt
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_NO_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done); // R7
    AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(psc) && $stable(low_cnt) && $stable(high_cnt) && $stable(fail))); // R8
    AST_FAIL_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (psc == '0 && low_cnt == '0 && high_cnt == '0)); // R4
    AST_ACCEPT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> (low_cnt != '0 && high_cnt != '0)); // R2
    AST_ZERO_SPEED_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && scl_hz == '0) |=> (done && fail)); // R5
    AST_START_BEGINS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && scl_hz != '0) |=> busy); // R7
endmodule

bind i2c_clkdiv_search i2c_clkdiv_search_chk #(
    .FREQ_W(FREQ_W), .PSC_W(PSC_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .scl_hz(scl_hz), .busy(busy), .done(done),
    .fail(fail), .psc(psc), .low_cnt(low_cnt), .high_cnt(high_cnt)
);

// File: tb/i2c_clkdiv_search_tb.sv
module i2c_clkdiv_search_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] fclk_hz = '0;
    logic [31:0] scl_hz = '0;
    logic [7:0]  trim_lo = '0;
    logic [7:0]  trim_hi = '0;
    logic        busy, done, fail;
    logic [7:0]  psc, low_cnt, high_cnt;

    int errors = 0;
    int checks = 0;
    longint unsigned cyc = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    i2c_clkdiv_search u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .fclk_hz(fclk_hz), .scl_hz(scl_hz),
        .trim_lo(trim_lo), .trim_hi(trim_hi), .busy(busy), .done(done), .fail(fail),
        .psc(psc), .low_cnt(low_cnt), .high_cnt(high_cnt)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural model of the search: returns prescaler, counts, failure flag and cycle count.
    task automatic model(input longint f, input longint s, input longint tl, input longint th,
                         output longint p, output longint lo, output longint hi,
                         output bit fl, output longint lat);
        fl = 1'b1; p = 0; lo = 0; hi = 0; lat = 69 * 256;
        if (s == 0) begin
            lat = 0;
            return;
        end
        for (int k = 0; k < 256; k++) begin
            longint d, a, b;
            d = (f / (k + 1)) / (2 * s);
            a = d - tl;
            b = d - th;
            if (a > 0 && b > 0 && a <= 255 - tl && b <= 255 - th) begin
                fl = 1'b0; p = k; lo = a; hi = b; lat = 69 * (k + 1);
                return;
            end
        end
    endtask

    // Runs one request, optionally with a stray start while busy; checks each cycle.
    task automatic run(input longint f, input longint s, input int tl, input int th,
                       input bit stray, input string tag);
        longint ep, elo, ehi, elat, n;
        bit efl;
        logic [7:0] hp, hl, hh;
        logic hf;
        model(f, s, tl, th, ep, elo, ehi, efl, elat);
        hp = psc; hl = low_cnt; hh = high_cnt; hf = fail;
        @(negedge clk);
        fclk_hz = 32'(f); scl_hz = 32'(s); trim_lo = 8'(tl); trim_hi = 8'(th);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < elat + 5) begin
            chk(busy === 1'b1, "R7 busy during search", busy, 1);
            chk(psc === hp && low_cnt === hl && high_cnt === hh && fail === hf,
                "R8 outputs held while searching", psc, hp);
            if (stray && n == 10) begin
                fclk_hz = 32'd1000; scl_hz = 32'd0; trim_lo = 8'd200; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(done === 1'b1 && n == elat, {"R6 completion cycle ", tag}, n, elat);
        chk(busy === 1'b0, {"R7 idle at done ", tag}, busy, 0);
        chk(fail === efl, {"R3 R4 fail flag ", tag}, fail, efl);
        chk(psc == ep, {"R3 prescaler ", tag}, psc, ep);
        chk(low_cnt == elo, {"R1 R2 low count ", tag}, low_cnt, elo);
        chk(high_cnt == ehi, {"R1 R2 high count ", tag}, high_cnt, ehi);
        hp = psc; hl = low_cnt; hh = high_cnt; hf = fail;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(done === 1'b0, {"R6 single-cycle done ", tag}, done, 0);
            chk(psc === hp && low_cnt === hl && high_cnt === hh && fail === hf,
                {"R8 outputs held after done ", tag}, low_cnt, hl);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && fail === 1'b0, "R9 reset flags", busy, 0);
        chk(psc === 8'd0 && low_cnt === 8'd0 && high_cnt === 8'd0, "R9 reset outputs", psc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 first candidate accepted
        run(48000000, 100000, 7, 5, 1'b0, "p0");
        // R3 first candidate too large, second accepted
        run(96000000, 100000, 7, 5, 1'b0, "p1");
        // R2 count exactly at the ceiling with zero trims
        run(510000, 1000, 0, 0, 1'b0, "ceiling");
        // R2 one above the ceiling moves to the next prescaler
        run(512000, 1000, 0, 0, 1'b0, "over");
        // R2 trims push the count to zero for a phase
        run(12000, 1000, 6, 5, 1'b0, "trimzero");
        // R4 count zero everywhere
        run(1000, 1000, 0, 0, 1'b0, "tooslow");
        // R4 every candidate too large
        run(64'd4000000000, 10000, 7, 5, 1'b0, "toofast");
        // R5 zero speed
        run(48000000, 0, 7, 5, 1'b0, "zero");
        // R7 stray start while busy is ignored
        run(200000000, 400000, 7, 5, 1'b1, "stray");
        // R3 a deeper search with asymmetric trims
        run(100000000, 10000, 3, 9, 1'b0, "deep");
        run(64'd3000000000, 50000, 1, 1, 1'b0, "wide");
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule